// File: doc/BRIEF.md
# Cascadable 4-bit ALU Slice

This block is a purely combinational arithmetic and logic slice that works on a 4-bit section of a wider datapath. It takes a left operand and a right operand and produces an OR, AND, XOR or sum of them. Two copies chained carry-out to carry-in form an 8-bit ALU. Shifting and flag generation belong to a downstream stage. To support that stage, the slice forwards the raw top bits of both buses and its raw carry input.

Each operand passes through a conditioner before use. The conditioner can force the operand to zero, and on the right side it can also invert it. Forcing the left operand to zero while selecting OR copies the right operand unchanged, so a single operation code also serves as a move. Subtraction is addition with the right operand inverted and a carry of one forced into the lowest slice. The upper slices take the external carry, which is the carry-out of the slice below.

Top module: `alu_slice`

## Requirements
- R1: With `op_sel` = 2'b00 the result is the bitwise OR of the conditioned left and right operands. With the left operand forced to zero and no inversion, the result equals the right operand, which makes this a move.
- R2: With `op_sel` = 2'b01 the result is the bitwise AND of the conditioned operands.
- R3: With `op_sel` = 2'b10 the result is the bitwise XOR of the conditioned operands.
- R4: With `op_sel` = 2'b11 the result is the low 4 bits of left + right + adder carry-in, all taken after conditioning.
- R5: When `lhs_zero` is 1 the left operand is replaced by zero. When it is 0 the value of `lhs_bus` is used.
- R6: When `rhs_zero` is 1 the right operand is replaced by zero. When it is 0 the value of `rhs_bus` is used.
- R7: When `rhs_inv` is 1 the right operand is bitwise inverted for every operation. Inversion is applied after zero replacement, so zero with inversion gives 4'hF.
- R8: The adder carry-in is chosen by `csel`: 2'b00 gives 0, 2'b01 gives 1, 2'b10 gives `carry_ext`, and 2'b11 gives 0.
- R9: `adder_cout` is always the carry out of left + right + adder carry-in, whatever operation is selected.
- R10: `lhs_msb_thru` equals `lhs_bus[3]`, `rhs_msb_thru` equals `rhs_bus[3]`, and `carry_thru` equals `carry_ext`. All three are taken before zero replacement and inversion.
- R11: Two slices perform an 8-bit subtraction. The low slice uses `csel` = 2'b01 with inversion. The high slice uses `csel` = 2'b10 with inversion and has its `carry_ext` fed from the low slice's `adder_cout`. The combined result is the 8-bit difference mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lhs_bus | input | 4 | Left operand from the bus |
| rhs_bus | input | 4 | Right operand from the bus |
| op_sel | input | 2 | Operation: 00 OR, 01 AND, 10 XOR, 11 ADD |
| carry_ext | input | 1 | External carry (status bit or lower slice carry-out) |
| lhs_zero | input | 1 | Replace left operand by zero |
| rhs_zero | input | 1 | Replace right operand by zero |
| csel | input | 2 | Adder carry-in choice: 00 zero, 01 one, 10 external, 11 zero |
| rhs_inv | input | 1 | Invert right operand after zero replacement |
| result | output | 4 | Selected operation result |
| adder_cout | output | 1 | Adder carry out, always computed |
| lhs_msb_thru | output | 1 | Raw copy of lhs_bus bit 3 |
| rhs_msb_thru | output | 1 | Raw copy of rhs_bus bit 3 |
| carry_thru | output | 1 | Raw copy of carry_ext |

## Verification
The hardest case to reach is the one where conditioning and pass-through disagree. Here the forwarded top bits and carry must still show the raw bus values while zero replacement and inversion change what the operations see. The case must also show that the carry-out reflects the sum while a logic operation is selected. Random control words rarely hit every combination of zero, invert and carry choice together with carry-producing operands. For that reason the stimulus adds directed sweeps over all control encodings with all-ones and all-zero operands. It also runs a chained two-slice subtraction in which the upper slice's carry comes only from the lower slice.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [1:0] {
    OP_OR  = 2'b00,
    OP_AND = 2'b01,
    OP_XOR = 2'b10,
    OP_ADD = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    CI_ZERO   = 2'b00,
    CI_ONE    = 2'b01,
    CI_EXT    = 2'b10,
    CI_ZERO_B = 2'b11
  } carry_src_e;

  function automatic logic pick_carry(input carry_src_e src, input logic ext);
    logic c;
    case (src)
      CI_ONE:  c = 1'b1;
      CI_EXT:  c = ext;
      default: c = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int WIDTH   = 4,
  parameter bit CAN_INV = 1'b1
) (
  input  logic [WIDTH-1:0] bus_val,
  input  logic             zero_en,
  input  logic             inv_en,
  output logic [WIDTH-1:0] opnd
);

  logic [WIDTH-1:0] gated;

  always_comb begin
    gated = zero_en ? '0 : bus_val;
  end

  generate
    if (CAN_INV) begin : g_inv
      always_comb begin
        opnd = inv_en ? ~gated : gated;
      end
    end else begin : g_plain
      logic unused_inv;
      always_comb begin
        unused_inv = inv_en;
        opnd       = gated;
      end
    end
  endgenerate

  // Zero replacement precedes inversion.
  always_comb begin
    if (zero_en && inv_en && CAN_INV) begin
      p_zero_inv_r7: assert (opnd == {WIDTH{1'b1}})
        else $error("zero+invert must give all ones");
    end
    if (zero_en && !(inv_en && CAN_INV)) begin
      p_zero_r5: assert (opnd == '0)
        else $error("zero select must give zero");
    end
  end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] xor_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign or_o[i]  = a[i] | b[i];
    assign and_o[i] = a[i] & b[i];
    assign xor_o[i] = a[i] ^ b[i];
  end

  // XOR and AND partition the OR set.
  always_comb begin
    p_partition_r3: assert (((and_o | xor_o) == or_o) && ((and_o & xor_o) == '0))
      else $error("bitwise outputs inconsistent");
  end

endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  logic [WIDTH:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    logic prop;
    logic gen;
    assign prop        = a[i] ^ b[i];
    assign gen         = a[i] & b[i];
    assign sum[i]      = prop ^ chain[i];
    assign chain[i+1]  = gen | (prop & chain[i]);
  end

  assign cout = chain[WIDTH];

  logic [WIDTH:0] arith_ref;
  always_comb begin
    arith_ref = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    p_ripple_sum_r4: assert ({cout, sum} == arith_ref)
      else $error("ripple chain disagrees with arithmetic sum");
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] lhs_bus,
  input  logic [WIDTH-1:0] rhs_bus,
  input  logic [1:0]       op_sel,
  input  logic             carry_ext,
  input  logic             lhs_zero,
  input  logic             rhs_zero,
  input  logic [1:0]       csel,
  input  logic             rhs_inv,
  output logic [WIDTH-1:0] result,
  output logic             adder_cout,
  output logic             lhs_msb_thru,
  output logic             rhs_msb_thru,
  output logic             carry_thru
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] lhs_op;
  logic [WIDTH-1:0] rhs_op;
  logic [WIDTH-1:0] or_v;
  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] xor_v;
  logic [WIDTH-1:0] sum_v;
  logic             add_cin;
  alu_op_e          op;

  alu_operand_cond #(.WIDTH(WIDTH), .CAN_INV(1'b0)) u_lhs_cond (
    .bus_val (lhs_bus),
    .zero_en (lhs_zero),
    .inv_en  (1'b0),
    .opnd    (lhs_op)
  );

  alu_operand_cond #(.WIDTH(WIDTH), .CAN_INV(1'b1)) u_rhs_cond (
    .bus_val (rhs_bus),
    .zero_en (rhs_zero),
    .inv_en  (rhs_inv),
    .opnd    (rhs_op)
  );

  alu_bitwise #(.WIDTH(WIDTH)) u_logic (
    .a     (lhs_op),
    .b     (rhs_op),
    .or_o  (or_v),
    .and_o (and_v),
    .xor_o (xor_v)
  );

  always_comb begin
    add_cin = pick_carry(carry_src_e'(csel), carry_ext);
  end

  alu_ripple_add #(.WIDTH(WIDTH)) u_adder (
    .a    (lhs_op),
    .b    (rhs_op),
    .cin  (add_cin),
    .sum  (sum_v),
    .cout (adder_cout)
  );

  always_comb begin
    op = alu_op_e'(op_sel);
    case (op)
      OP_OR:   result = or_v;
      OP_AND:  result = and_v;
      OP_XOR:  result = xor_v;
      OP_ADD:  result = sum_v;
      default: result = or_v;
    endcase
  end

  assign lhs_msb_thru = lhs_bus[MSB];
  assign rhs_msb_thru = rhs_bus[MSB];
  assign carry_thru   = carry_ext;

  always_comb begin
    if (op_sel == 2'b00 && lhs_zero && !rhs_zero && !rhs_inv) begin
      p_move_r1: assert (result == rhs_bus)
        else $error("OR with zero left must move right operand");
    end
    if (csel == 2'b00 || csel == 2'b11) begin
      p_cin_zero_r8: assert (adder_cout == (({1'b0, lhs_op} + {1'b0, rhs_op}) > MSB'(0) + (1 << WIDTH) - 1))
        else $error("carry-out with forced zero carry-in wrong");
    end
  end

endmodule

// File: tb/alu_slice_tb.sv
module alu_slice_tb;

  localparam int W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] lhs_bus, rhs_bus, result;
  logic [1:0]   op_sel, csel;
  logic         carry_ext, lhs_zero, rhs_zero, rhs_inv;
  logic         adder_cout, lhs_msb_thru, rhs_msb_thru, carry_thru;

  logic [W-1:0] hi_lhs, hi_rhs, hi_result;
  logic         hi_cout, hi_lt, hi_rt, hi_ct;

  int n_tests = 0;
  int n_fail  = 0;

  alu_slice #(.WIDTH(W)) u_dut (
    .lhs_bus(lhs_bus), .rhs_bus(rhs_bus), .op_sel(op_sel), .carry_ext(carry_ext),
    .lhs_zero(lhs_zero), .rhs_zero(rhs_zero), .csel(csel), .rhs_inv(rhs_inv),
    .result(result), .adder_cout(adder_cout), .lhs_msb_thru(lhs_msb_thru),
    .rhs_msb_thru(rhs_msb_thru), .carry_thru(carry_thru)
  );

  alu_slice #(.WIDTH(W)) u_hi (
    .lhs_bus(hi_lhs), .rhs_bus(hi_rhs), .op_sel(2'b11), .carry_ext(adder_cout),
    .lhs_zero(1'b0), .rhs_zero(1'b0), .csel(2'b10), .rhs_inv(1'b1),
    .result(hi_result), .adder_cout(hi_cout), .lhs_msb_thru(hi_lt),
    .rhs_msb_thru(hi_rt), .carry_thru(hi_ct)
  );

  function automatic logic [W:0] model(
    input logic [W-1:0] l, input logic [W-1:0] r, input logic [1:0] op,
    input logic cx, input logic lz, input logic rz, input logic [1:0] cs, input logic inv);
    logic [W-1:0] a, b, res;
    logic [W:0]   s;
    logic         ci;
    a  = lz ? '0 : l;
    b  = rz ? '0 : r;
    if (inv) b = ~b;
    ci = (cs == 2'b01) ? 1'b1 : (cs == 2'b10) ? cx : 1'b0;
    s  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    case (op)
      2'b00: res = a | b;
      2'b01: res = a & b;
      2'b10: res = a ^ b;
      default: res = s[W-1:0];
    endcase
    return {s[W], res};
  endfunction

  task automatic apply(input logic [W-1:0] l, input logic [W-1:0] r, input logic [1:0] op,
                       input logic cx, input logic lz, input logic rz, input logic [1:0] cs,
                       input logic inv, input string tag);
    logic [W:0] exp;
    @(posedge clk);
    lhs_bus = l; rhs_bus = r; op_sel = op; carry_ext = cx;
    lhs_zero = lz; rhs_zero = rz; csel = cs; rhs_inv = inv;
    @(negedge clk);
    exp = model(l, r, op, cx, lz, rz, cs, inv);
    n_tests++;
    if ({adder_cout, result} !== exp) begin
      n_fail++;
      $display("FAIL %s: {cout,result} actual %h expected %h (l=%h r=%h op=%b cx=%b lz=%b rz=%b cs=%b inv=%b)",
               tag, {adder_cout, result}, exp, l, r, op, cx, lz, rz, cs, inv);
    end
    n_tests++;
    if ({lhs_msb_thru, rhs_msb_thru, carry_thru} !== {l[W-1], r[W-1], cx}) begin
      n_fail++;
      $display("FAIL R10: thru actual %b expected %b", {lhs_msb_thru, rhs_msb_thru, carry_thru},
               {l[W-1], r[W-1], cx});
    end
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
          $finish;
        end
      end
    join_none

    void'($urandom(32'd4711));
    hi_lhs = '0; hi_rhs = '0;
    apply(4'h0, 4'h0, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R1 idle zero");
    apply(4'h5, 4'hA, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R1 or");
    apply(4'h9, 4'h6, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, "R1 move");
    apply(4'hC, 4'hA, 2'b01, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R2 and");
    apply(4'hC, 4'hA, 2'b10, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R3 xor");
    apply(4'h7, 4'h9, 2'b11, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R4 add wrap");
    apply(4'hF, 4'h3, 2'b01, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, "R5 left zero");
    apply(4'hF, 4'hF, 2'b00, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0, "R6 right zero");
    apply(4'h0, 4'hB, 2'b00, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, "R7 zero then invert");
    apply(4'h3, 4'h5, 2'b10, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, "R7 invert");
    for (int cs = 0; cs < 4; cs++) begin
      apply(4'hF, 4'h0, 2'b11, 1'b1, 1'b0, 1'b0, cs[1:0], 1'b0, "R8 carry select ext=1");
      apply(4'hF, 4'h0, 2'b11, 1'b0, 1'b0, 1'b0, cs[1:0], 1'b0, "R8 carry select ext=0");
    end
    for (int op = 0; op < 3; op++)
      apply(4'hF, 4'h1, op[1:0], 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R9 cout during logic op");
    apply(4'h8, 4'h8, 2'b11, 1'b1, 1'b1, 1'b1, 2'b10, 1'b1, "R10 thru raw");

    // R11 cascade subtraction
    for (int k = 0; k < 40; k++) begin
      logic [7:0] x, y, d;
      x = 8'($urandom); y = 8'($urandom);
      if (k == 0) begin x = 8'h00; y = 8'h01; end
      if (k == 1) begin x = 8'h80; y = 8'h7F; end
      d = x - y;
      @(posedge clk);
      hi_lhs = x[7:4]; hi_rhs = y[7:4];
      lhs_bus = x[3:0]; rhs_bus = y[3:0]; op_sel = 2'b11; carry_ext = 1'b0;
      lhs_zero = 1'b0; rhs_zero = 1'b0; csel = 2'b01; rhs_inv = 1'b1;
      @(negedge clk);
      n_tests++;
      if ({hi_result, result} !== d) begin
        n_fail++;
        $display("FAIL R11: diff actual %h expected %h (x=%h y=%h)", {hi_result, result}, d, x, y);
      end
    end

    for (int k = 0; k < 600; k++) begin
      logic [15:0] v;
      v = 16'($urandom);
      apply(W'($urandom), W'($urandom), v[1:0], v[2], v[3] & v[4], v[5] & v[6], v[8:7], v[9],
            "R4 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule